// File: doc/BRIEF.md
# Parallel Pin Serializer with Change-Triggered SPI Frames

This block carries a set of parallel signals across a serial link in the SPI style. On every system clock it captures its parallel input pins into a sample register. A host can instead write a word into an alternate data register. A source-select control decides which of the two words is sent. The block acts as link master. It drives chip select, a divided serial clock and the data-out line. It shifts a frame of 4 to 16 bits, most significant bit first.

A frame does not need a software command to start. The block keeps the last frame it sent in a comparison register. While idle, it starts a new frame on either of two events. The first is a mismatch between the selected source and that copy, looking only at the bits inside the configured frame length. The second is an external trigger pin, when the trigger is enabled. Each start is announced by a single-cycle pulse on a trigger output. At the same time, the block samples the incoming serial line and collects the received bits. When a frame completes, the received bits drive the parallel output pins. The host can read them back through the register port.

The register port is a single-cycle write strobe with a combinational read. The addresses are: 0 control, 1 clock divider, 2 alternate data, 3 sample (read only), 4 comparison (read only), 5 received (read only). Other addresses read as zero.

Top module: `pio_spi_bridge`

## Requirements
- R1: After reset, cs_n is high, sck is low and xfer_trig is low. par_out and the comparison and received registers (addresses 4 and 5) read zero. No frame starts while both enable bits are clear, even if par_in changes.
- R2: The sample register (address 3) takes par_in on every clock edge.
- R3: Control bits [4:0] set the frame length N. Values below 4 act as 4 and values above 16 act as 16. A frame shifts exactly N bits on mosi, MSB first, and these are the low N bits of the selected word.
- R4: sck is low whenever cs_n is high, and cs_n stays low for the whole frame. Bits on mosi are sampled by the receiver on the sck rising edge. Divider bits [7:0] give the half period H in system clocks, with 0 treated as 1. Each sck high phase lasts exactly H clocks.
- R5: Control bit 5 selects the source. 0 sends the sample register and 1 sends the alternate register (address 2). The source that is not selected has no effect on frame starts.
- R6: After a frame ends, the comparison register (address 4) holds the N transmitted bits, with the upper bits zero.
- R7: With control bit 6 set and no frame running, a difference between the selected word and the comparison register in the low N bits starts a frame. A difference only in bits N and above starts none. Once the two agree, no further frame follows.
- R8: With control bit 7 set, a high hw_trig while idle starts a frame even when the data is unchanged. With bit 7 clear, hw_trig has no effect.
- R9: xfer_trig is high for exactly one clock, in the first clock in which cs_n is low.
- R10: A hw_trig pulse during a running frame is dropped. It neither restarts the frame nor queues a later one.
- R11: miso is sampled on each sck rising edge, MSB first. At frame end, par_out and the received register (address 5) hold the N received bits, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| par_in | input | 16 | Parallel input pins |
| par_out | output | 16 | Parallel output pins from the last received frame |
| hw_trig | input | 1 | External transfer request |
| xfer_trig | output | 1 | One-cycle pulse at each frame start |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A stale or corrupted comparison register shows up at the ports in two ways. It causes an extra frame within two clocks of idling, or it leaves a pin change with no frame at all. Either way the frame count shows it at once, and the readback at address 4 exposes it. A bit counter or shifter that is off by one changes the length or content of the very next frame seen on mosi, and the par_out word at its end. A divider error appears in the width of the first sck high phase. The bench sweeps every length field from 2 to 20 against half periods 0 to 3, with chosen patterns. This makes such faults visible within one frame.

// File: rtl/pio_spi_pkg.sv
package pio_spi_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
    localparam logic [ADDR_W-1:0] A_ALT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SAMP = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd4;
    localparam logic [ADDR_W-1:0] A_RX   = 3'd5;

    localparam int B_SRC = 5;
    localparam int B_CHG = 6;
    localparam int B_TRG = 7;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] half;
        logic       src_alt;
        logic       chg_en;
        logic       trig_en;
    } cfg_t;
endpackage

// File: rtl/pio_spi_regs.sv
module pio_spi_regs
    import pio_spi_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MIN_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [DATA_W-1:0]   par_in,
    input  logic [DATA_W-1:0]   cmp_word,
    input  logic [DATA_W-1:0]   rx_word,
    output cfg_t                cfg,
    output logic [DATA_W-1:0]   alt_word,
    output logic [DATA_W-1:0]   samp_word
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] div;
        logic [DATA_W-1:0] alt;
        logic [DATA_W-1:0] samp;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d      = q;
        d.samp = par_in;
        if (we) begin
            case (addr)
                A_CTRL:  d.ctrl = wdata;
                A_DIV:   d.div  = wdata;
                A_ALT:   d.alt  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic [7:0] len_field;
    always_comb begin
        len_field   = {3'b000, q.ctrl[4:0]};
        if (len_field < 8'(MIN_LEN))     cfg.len = 8'(MIN_LEN);
        else if (len_field > 8'(DATA_W)) cfg.len = 8'(DATA_W);
        else                             cfg.len = len_field;
        cfg.half    = (q.div[7:0] == 8'd0) ? 8'd1 : q.div[7:0];
        cfg.src_alt = q.ctrl[B_SRC];
        cfg.chg_en  = q.ctrl[B_CHG];
        cfg.trig_en = q.ctrl[B_TRG];
    end

    assign alt_word  = q.alt;
    assign samp_word = q.samp;

    always_comb begin
        case (addr)
            A_CTRL:  rdata = q.ctrl;
            A_DIV:   rdata = q.div;
            A_ALT:   rdata = q.alt;
            A_SAMP:  rdata = q.samp;
            A_CMP:   rdata = cmp_word;
            A_RX:    rdata = rx_word;
            default: rdata = '0;
        endcase
    end

    assert_sample_each_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q.samp == $past(par_in)));
endmodule

// File: rtl/pio_spi_trigger.sv
module pio_spi_trigger
    import pio_spi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic [DATA_W-1:0] samp_word,
    input  logic [DATA_W-1:0] alt_word,
    input  logic [DATA_W-1:0] cmp_word,
    input  logic              busy,
    input  logic              hw_trig,
    output logic              start,
    output logic [DATA_W-1:0] frame_word,
    output logic              trig_pulse
);
    typedef struct packed {
        logic pulse;
    } trg_t;

    trg_t q, d;
    logic [DATA_W:0]   one_ext;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] src;
    logic              changed;

    always_comb begin
        one_ext    = {{DATA_W{1'b0}}, 1'b1};
        mask       = DATA_W'((one_ext << cfg.len) - 1'b1);
        src        = cfg.src_alt ? alt_word : samp_word;
        frame_word = src & mask;
        changed    = |((src ^ cmp_word) & mask);
        start      = !busy && ((cfg.chg_en && changed) || (cfg.trig_en && hw_trig));
        d          = q;
        d.pulse    = start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign trig_pulse = q.pulse;

    assert_trig_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |=> !q.pulse);
    assert_disabled_hw_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.chg_en && !cfg.trig_en) |-> !start);
endmodule

// File: rtl/pio_spi_engine.sv
module pio_spi_engine #(
    parameter int DATA_W  = 16,
    parameter int MIN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] word,
    input  logic [7:0]        len,
    input  logic [7:0]        half,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] cmp_word,
    output logic [DATA_W-1:0] rx_word
);
    typedef struct packed {
        logic              busy;
        logic              sck;
        logic [7:0]        cnt;
        logic [7:0]        left;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] cmp;
        logic [DATA_W-1:0] dout;
    } eng_t;

    eng_t q, d;
    logic [7:0] align;

    always_comb begin
        d     = q;
        align = 8'(DATA_W) - len;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sck  = 1'b0;
                d.cnt  = '0;
                d.left = len;
                d.tx   = word << align;
                d.rx   = '0;
                d.word = word;
            end
        end else if (q.cnt == half - 8'd1) begin
            d.cnt = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[DATA_W-2:0], miso};
            end else begin
                d.sck  = 1'b0;
                d.tx   = q.tx << 1;
                d.left = q.left - 8'd1;
                if (q.left == 8'd1) begin
                    d.busy = 1'b0;
                    d.cmp  = q.word;
                    d.dout = q.rx;
                end
            end
        end else begin
            d.cnt = q.cnt + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign sck      = q.sck;
    assign mosi     = q.busy & q.tx[DATA_W-1];
    assign cmp_word = q.cmp;
    assign rx_word  = q.dout;

    assert_sck_low_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.sck);
    assert_len_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> (q.left >= 8'(MIN_LEN) && q.left <= 8'(DATA_W)));
    assert_word_held_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> $stable(q.word));
    assert_cmp_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (q.cmp == $past(q.word)));
endmodule

// File: rtl/pio_spi_bridge.sv
module pio_spi_bridge
    import pio_spi_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MIN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] par_in,
    output logic [DATA_W-1:0] par_out,
    input  logic              hw_trig,
    output logic              xfer_trig,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    cfg_t              cfg;
    logic [DATA_W-1:0] alt_word, samp_word, cmp_word, rx_word, frame_word;
    logic              busy, start;

    pio_spi_regs #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .par_in(par_in),
        .cmp_word(cmp_word), .rx_word(rx_word), .cfg(cfg),
        .alt_word(alt_word), .samp_word(samp_word)
    );

    pio_spi_trigger #(.DATA_W(DATA_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .samp_word(samp_word),
        .alt_word(alt_word), .cmp_word(cmp_word), .busy(busy),
        .hw_trig(hw_trig), .start(start), .frame_word(frame_word),
        .trig_pulse(xfer_trig)
    );

    pio_spi_engine #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .word(frame_word),
        .len(cfg.len), .half(cfg.half), .miso(miso), .busy(busy),
        .sck(sck), .mosi(mosi), .cmp_word(cmp_word), .rx_word(rx_word)
    );

    assign cs_n    = !busy;
    assign par_out = rx_word;

    assert_trig_at_cs_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_trig |-> (!cs_n && $past(cs_n)));
endmodule

// File: tb/tb_pio_spi_bridge.sv
`timescale 1ns/1ps
module tb_pio_spi_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] par_in = '0;
    logic [15:0] par_out;
    logic        hw_trig = 1'b0;
    logic        xfer_trig, sck, mosi, cs_n;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    pio_spi_bridge dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .par_in(par_in),
        .par_out(par_out), .hw_trig(hw_trig), .xfer_trig(xfer_trig),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial monitor / slave model
    int          cur_len = 4;
    int          exp_half = 1;
    logic [15:0] rx_pat = '0;
    int          mon_frames = 0;
    int          mon_bits = 0;
    logic [15:0] mon_acc = '0;
    logic [15:0] mon_word = '0;
    int          hi_cnt = 0;
    int          bitpos = 0;
    logic        prev_cs = 1'b1;
    logic        prev_sck = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_trig || (prev_cs && !cs_n))
                check("R9 trigger pulse at cs_n fall", {31'd0, xfer_trig && prev_cs && !cs_n}, 32'd1);
            if (prev_cs && !cs_n) begin
                mon_bits = 0;
                mon_acc  = '0;
                bitpos   = cur_len - 1;
                miso     = rx_pat[bitpos];
            end
            if (!cs_n && !prev_sck && sck) begin
                mon_acc = {mon_acc[14:0], mosi};
                mon_bits++;
            end
            if (sck) hi_cnt++;
            if (prev_sck && !sck) begin
                check("R4 sck high phase", hi_cnt, exp_half);
                hi_cnt = 0;
                if (!cs_n && bitpos > 0) begin
                    bitpos--;
                    miso = rx_pat[bitpos];
                end
            end
            if (!prev_cs && cs_n) begin
                check("R4 sck low after frame", {31'd0, sck}, 32'd0);
                mon_word = mon_acc;
                mon_frames++;
            end
            prev_cs  = cs_n;
            prev_sck = sck;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_frames(input string req, input int target);
        for (int i = 0; i < 3000 && mon_frames < target; i++) @(negedge clk);
        check(req, mon_frames, target);
    endtask

    function automatic int eff_len(input int f);
        return (f < 4) ? 4 : (f > 16) ? 16 : f;
    endfunction

    function automatic logic [15:0] msk(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    logic [15:0] exp_cmp = '0;
    logic [15:0] rv;

    task automatic run_frame(input int lenf, input int halff, input logic [15:0] pat0,
                             input logic [15:0] rxp, input bit use_alt);
        logic [15:0] pat, m;
        logic [7:0]  base;
        int          start_f;
        int          el;
        el   = eff_len(lenf);
        m    = msk(el);
        pat  = pat0;
        if (((pat ^ exp_cmp) & m) == 0) pat = pat ^ 16'h0001;
        base = {1'b0, 1'b0, use_alt, 5'(lenf)};
        wr(3'd0, {8'd0, base});
        wr(3'd1, 16'(halff));
        if (use_alt) wr(3'd2, pat);
        else         par_in = pat;
        rx_pat   = rxp;
        cur_len  = el;
        exp_half = (halff == 0) ? 1 : halff;
        idle(2);
        start_f = mon_frames;
        wr(3'd0, {8'd0, base | 8'h40});
        wait_frames("R7 change starts frame", start_f + 1);
        check("R3 bit count", mon_bits, el);
        check("R3 frame content MSB first", mon_word, pat & m);
        exp_cmp = pat & m;
        rd(3'd4, rv);
        check("R6 comparison readback", rv, pat & m);
        check("R11 par_out", par_out, rxp & m);
        rd(3'd5, rv);
        check("R11 received readback", rv, rxp & m);
        idle(40);
        check("R7 no repeat when equal", mon_frames, start_f + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int f0;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 cs_n", {31'd0, cs_n}, 1);
        check("R1 sck", {31'd0, sck}, 0);
        check("R1 xfer_trig", {31'd0, xfer_trig}, 0);
        check("R1 par_out", par_out, 0);
        rd(3'd4, rv); check("R1 cmp", rv, 0);
        rd(3'd5, rv); check("R1 rx", rv, 0);
        // R1 nothing starts with enables clear; R2 sampling
        for (int k = 0; k < 8; k++) begin
            par_in = 16'h1357 * 16'(k + 1);
            idle(2);
            rd(3'd3, rv);
            check("R2 sample register", rv, 16'h1357 * 16'(k + 1));
        end
        idle(20);
        check("R1 no frame without enable", mon_frames, 0);

        // R3/R4/R6/R7/R11 sweep of length field and divider
        for (int lf = 2; lf <= 20; lf++) begin
            for (int hf = 0; hf <= 3; hf++) begin
                run_frame(lf, hf, 16'hA5C3 ^ 16'(lf * 16'h0911) ^ 16'(hf * 16'h3003),
                          16'h6B2D ^ 16'(lf * 16'h1021) ^ 16'(hf << 3), 1'b0);
            end
        end

        // R7 upper bits beyond N ignored
        run_frame(8, 1, 16'h00C4, 16'h005A, 1'b0);
        f0 = mon_frames;
        par_in = par_in ^ 16'hFF00;
        idle(40);
        check("R7 change above N ignored", mon_frames, f0);
        par_in = par_in ^ 16'h0010;
        wait_frames("R7 change within N starts", f0 + 1);
        check("R7 new word sent", mon_word, par_in & 16'h00FF);
        exp_cmp = par_in & 16'h00FF;
        idle(20);

        // R5 alternate source
        run_frame(12, 2, 16'h0ABC, 16'h0F0F, 1'b1);
        f0 = mon_frames;
        par_in = 16'h0555;
        idle(40);
        check("R5 pins ignored with alt source", mon_frames, f0);
        rd(3'd4, rv);
        check("R5 cmp unchanged", rv, exp_cmp);

        // R8 hardware trigger
        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h0002);
        cur_len = 8; exp_half = 2;
        par_in = exp_cmp;
        idle(4);
        f0 = mon_frames;
        @(negedge clk); hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
        idle(40);
        check("R8 trigger ignored when disabled", mon_frames, f0);
        wr(3'd0, 16'h0088);
        idle(4);
        check("R8 no start without trigger", mon_frames, f0);
        @(negedge clk); hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
        for (int i = 0; i < 50 && cs_n; i++) @(negedge clk);
        check("R8 trigger starts frame", {31'd0, cs_n}, 0);
        // R10 trigger during frame dropped
        idle(3);
        hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
        wait_frames("R8 triggered frame ends", f0 + 1);
        check("R8 unchanged word resent", mon_word, exp_cmp & 16'h00FF);
        idle(60);
        check("R10 mid-frame trigger dropped", mon_frames, f0 + 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule